// File: doc/BRIEF.md
# Programmable Wait State Controller

This block stretches bus cycles with wait clocks so that slow memories and peripherals have time to respond. Every bus cycle begins with a one-clock start strobe that carries the cycle's originator (processor, DMA engine or refresh logic), an I/O flag and the address. The block sorts the cycle into one of six wait classes: three processor memory areas, processor I/O, DMA and refresh. It loads that class's programmed wait count into a down-counter and holds the ready output low until the counter has run out.

A small register port sets the wait counts and two area boundaries. The boundaries are compared against the top bits of the address. Counts are two bits wide, so each cycle gets zero to three wait clocks. After reset every count is at its slowest setting.

Top module: `wait_state_ctrl`

## Requirements
- R1: After reset, ready is high, the read port returns 0xFFF at register 0 (every wait count is 3), 0x4 at register 1 and 0xC at register 2, and a cycle started with no further programming gets 3 wait clocks.
- R2: When a cycle starts with a selected count N, ready is low for exactly N clocks after the clock edge that samples the start strobe, and is high on the following clock.
- R3: When the selected count is 0, ready stays high through the whole cycle.
- R4: A cycle with master code 1 (DMA) uses register 0 bits [9:8], whatever its address or I/O flag.
- R5: A cycle with master code 2 (refresh) or the reserved code 3 uses register 0 bits [11:10].
- R6: A cycle with master code 0 (processor) and the I/O flag set uses register 0 bits [7:6], whatever its address.
- R7: A processor memory cycle compares the top 4 address bits U against the low boundary L (register 1) and the high boundary H (register 2). U < L selects the low area, which uses bits [1:0]. Otherwise U < H selects the middle area, which uses bits [3:2]. Otherwise the high area is selected, which uses bits [5:4].
- R8: A write with the write enable high stores the write data in the register at the given address: 0 holds the wait counts in bits [11:0], 1 and 2 hold the boundaries in bits [3:0]. A write to address 3 changes nothing. The read port returns the addressed register with its unused bits at zero.
- R9: A start strobe that arrives while a countdown is running discards it and loads the newly selected count.
- R10: A register write during a countdown does not change the length of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address for write and read |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Addressed register contents |
| cyc_start | input | 1 | One-clock strobe marking the first clock of a bus cycle |
| cyc_master | input | 2 | Cycle originator: 0 processor, 1 DMA, 2 refresh, 3 reserved |
| cyc_io | input | 1 | Processor cycle targets I/O space |
| cyc_addr | input | 16 | Cycle address |
| ready | output | 1 | High when the current cycle may complete |

## Verification
The assertions take for granted that the start strobe is a single clock wide per cycle, or deliberately repeated as a restart. They also assume that master, I/O flag and address are valid whenever the strobe is high. The stimulus drives all of these at the falling edge and samples ready at the following falling edges. It raises the strobe for one clock in every cycle except the restart test, where it is held for a second clock on purpose. Register writes are kept clear of start strobes except in the test that checks that a mid-cycle write leaves the running countdown alone.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int CNT_W   = 2;
    localparam int NUM_CLS = 6;
    localparam int CFG_DW  = 16;
    localparam int RA_W    = 2;
    localparam int WAITS_W = CNT_W * NUM_CLS;

    typedef enum logic [1:0] {
        MST_CPU  = 2'd0,
        MST_DMA  = 2'd1,
        MST_RFSH = 2'd2,
        MST_RSV  = 2'd3
    } master_e;

    typedef enum logic [2:0] {
        CLS_LOW  = 3'd0,
        CLS_MID  = 3'd1,
        CLS_HIGH = 3'd2,
        CLS_IO   = 3'd3,
        CLS_DMA  = 3'd4,
        CLS_RFSH = 3'd5
    } wclass_e;

    typedef enum logic [1:0] {
        AREA_LOW  = 2'd0,
        AREA_MID  = 2'd1,
        AREA_HIGH = 2'd2
    } area_e;

    typedef enum logic [RA_W-1:0] {
        REG_WAITS = 2'd0,
        REG_BLO   = 2'd1,
        REG_BHI   = 2'd2,
        REG_NONE  = 2'd3
    } regsel_e;

    typedef struct packed {
        logic    start;
        master_e master;
        logic    io;
    } cyc_ctl_t;

    localparam logic [CNT_W-1:0] CNT_RST = '1;

    function automatic wclass_e pick_class(master_e m, logic io, area_e a);
        wclass_e c;
        case (m)
            MST_CPU: begin
                if (io)
                    c = CLS_IO;
                else if (a == AREA_LOW)
                    c = CLS_LOW;
                else if (a == AREA_MID)
                    c = CLS_MID;
                else
                    c = CLS_HIGH;
            end
            MST_DMA: c = CLS_DMA;
            default: c = CLS_RFSH;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wsc_regs.sv
module wsc_regs
    import wsc_pkg::*;
#(
    parameter int              BND_W   = 4,
    parameter logic [BND_W-1:0] BLO_RST = 4'h4,
    parameter logic [BND_W-1:0] BHI_RST = 4'hC
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [RA_W-1:0]                 addr,
    input  logic [CFG_DW-1:0]               wdata,
    output logic [CFG_DW-1:0]               rdata,
    output logic [NUM_CLS-1:0][CNT_W-1:0]   waits,
    output logic [BND_W-1:0]                bnd_lo,
    output logic [BND_W-1:0]                bnd_hi
);

    regsel_e sel;
    assign sel = regsel_e'(addr);

    logic wr_waits, wr_lo, wr_hi;
    assign wr_waits = we && (sel == REG_WAITS);
    assign wr_lo    = we && (sel == REG_BLO);
    assign wr_hi    = we && (sel == REG_BHI);

    // One field register per wait class
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                waits[g] <= CNT_RST;
            else if (wr_waits)
                waits[g] <= wdata[g*CNT_W +: CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd_lo <= BLO_RST;
            bnd_hi <= BHI_RST;
        end else begin
            if (wr_lo) bnd_lo <= wdata[BND_W-1:0];
            if (wr_hi) bnd_hi <= wdata[BND_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_WAITS: rdata[WAITS_W-1:0] = waits;
            REG_BLO:   rdata[BND_W-1:0]   = bnd_lo;
            REG_BHI:   rdata[BND_W-1:0]   = bnd_hi;
            default:   rdata = '0;
        endcase
    end

    // R8
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(waits) && $stable(bnd_lo) && $stable(bnd_hi));

    // R8
    regs_none_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd3) |=> $stable(waits) && $stable(bnd_lo) && $stable(bnd_hi));

    // R1
    regs_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (waits == '1) && (bnd_lo == BLO_RST) && (bnd_hi == BHI_RST));

endmodule

// File: rtl/wsc_region.sv
module wsc_region
    import wsc_pkg::*;
#(
    parameter int BND_W = 4
) (
    input  logic [BND_W-1:0] upper,
    input  logic [BND_W-1:0] bnd_lo,
    input  logic [BND_W-1:0] bnd_hi,
    output area_e            area
);

    logic below_lo, below_hi;
    assign below_lo = upper < bnd_lo;
    assign below_hi = upper < bnd_hi;

    always_comb begin
        if (below_lo)
            area = AREA_LOW;
        else if (below_hi)
            area = AREA_MID;
        else
            area = AREA_HIGH;
    end

endmodule

// File: rtl/wsc_counter.sv
module wsc_counter
    import wsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             ready
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);

    // R2
    wait_low_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !ready);

    // R3
    zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> ready);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !ready) |=> (cnt == $past(cnt) - 1'b1));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && ready) |=> ready);

endmodule

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl
    import wsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BND_W  = 4,
    parameter logic [BND_W-1:0] BLO_RST = 4'h4,
    parameter logic [BND_W-1:0] BHI_RST = 4'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              cyc_start,
    input  logic [1:0]        cyc_master,
    input  logic              cyc_io,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              ready
);

    localparam int UP_LSB = ADDR_W - BND_W;

    logic [NUM_CLS-1:0][CNT_W-1:0] waits;
    logic [BND_W-1:0]              bnd_lo, bnd_hi;
    area_e                         area;
    wclass_e                       cls;
    logic [CNT_W-1:0]              sel_cnt;
    cyc_ctl_t                      ctl;

    assign ctl = '{start: cyc_start, master: master_e'(cyc_master), io: cyc_io};

    wsc_regs #(
        .BND_W   (BND_W),
        .BLO_RST (BLO_RST),
        .BHI_RST (BHI_RST)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .waits  (waits),
        .bnd_lo (bnd_lo),
        .bnd_hi (bnd_hi)
    );

    wsc_region #(
        .BND_W (BND_W)
    ) u_region (
        .upper  (cyc_addr[ADDR_W-1:UP_LSB]),
        .bnd_lo (bnd_lo),
        .bnd_hi (bnd_hi),
        .area   (area)
    );

    assign cls     = pick_class(ctl.master, ctl.io, area);
    assign sel_cnt = waits[cls];

    wsc_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.start),
        .load_val (sel_cnt),
        .ready    (ready)
    );

    // R4
    dma_class_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_master == 2'd1) |-> (sel_cnt == cfg_rdata_waits_dma()));

    // R6
    io_class_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_master == 2'd0 && cyc_io) |-> (sel_cnt == waits[CLS_IO]));

    // R5
    rfsh_class_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_master[1]) |-> (sel_cnt == waits[CLS_RFSH]));

    // R7
    high_area_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_master == 2'd0 && !cyc_io
         && cyc_addr[ADDR_W-1:UP_LSB] >= bnd_lo && cyc_addr[ADDR_W-1:UP_LSB] >= bnd_hi)
        |-> (sel_cnt == waits[CLS_HIGH]));

    function automatic logic [CNT_W-1:0] cfg_rdata_waits_dma();
        return waits[CLS_DMA];
    endfunction

endmodule

// File: tb/sim_wait_state_ctrl.sv
module sim_wait_state_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;
    localparam int NVEC       = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        cyc_start = 1'b0;
    logic [1:0]  cyc_master = 2'd0;
    logic        cyc_io = 1'b0;
    logic [15:0] cyc_addr = 16'h0;
    logic        ready;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wait_state_ctrl u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cyc_start(cyc_start), .cyc_master(cyc_master), .cyc_io(cyc_io), .cyc_addr(cyc_addr),
        .ready(ready)
    );

    // {master[1:0], io, addr[15:0], expected waits[1:0]} with wait register 0x6C9:
    // low=1 mid=2 high=0 io=3 dma=2 refresh=1, boundaries 4 and C
    localparam logic [20:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 16'h1000, 2'd1},   // R7 low
        {2'd0, 1'b0, 16'h3FFF, 2'd1},   // R7 low edge
        {2'd0, 1'b0, 16'h4000, 2'd2},   // R7 mid edge
        {2'd0, 1'b0, 16'hBFFF, 2'd2},   // R7 mid
        {2'd0, 1'b0, 16'hC000, 2'd0},   // R7/R3 high
        {2'd0, 1'b0, 16'hFFFF, 2'd0},   // R7 high
        {2'd0, 1'b1, 16'h0000, 2'd3},   // R6
        {2'd0, 1'b1, 16'hC000, 2'd3},   // R6
        {2'd1, 1'b0, 16'h0000, 2'd2},   // R4
        {2'd1, 1'b1, 16'hC000, 2'd2},   // R4
        {2'd2, 1'b0, 16'h5000, 2'd1},   // R5
        {2'd3, 1'b1, 16'hE000, 2'd1}    // R5 reserved code
    };

    task automatic check(input logic got, input logic exp, input string msg);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b", msg, got, exp);
        end
    endtask

    task automatic check16(input logic [15:0] got, input logic [15:0] exp, input string msg);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", msg, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string msg);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check16(cfg_rdata, exp, msg);
    endtask

    task automatic run_cycle(input logic [1:0] m, input logic io, input logic [15:0] a,
                             input int n, input string msg);
        @(negedge clk);
        cyc_start = 1'b1; cyc_master = m; cyc_io = io; cyc_addr = a;
        @(negedge clk);
        cyc_start = 1'b0;
        for (int i = 0; i <= n; i++) begin
            if (i > 0) @(negedge clk);
            check(ready, (i == n), msg);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check(ready, 1'b1, "R1 ready after reset");
        rd(2'd0, 16'h0FFF, "R1 wait register reset");
        rd(2'd1, 16'h0004, "R1 low boundary reset");
        rd(2'd2, 16'h000C, "R1 high boundary reset");
        run_cycle(2'd0, 1'b0, 16'h1000, 3, "R1 default wait count");

        // R8 programming and readback
        wr(2'd0, 16'hF6C9);
        rd(2'd0, 16'h06C9, "R8 wait register readback");
        wr(2'd3, 16'h0000);
        rd(2'd0, 16'h06C9, "R8 address 3 write ignored");
        rd(2'd3, 16'h0000, "R8 address 3 reads zero");

        // R2..R7 vector walk
        for (int v = 0; v < NVEC; v++) begin
            run_cycle(VEC[v][20:19], VEC[v][18], VEC[v][17:2], int'(VEC[v][1:0]),
                      $sformatf("R2 vector %0d", v));
        end

        // R9 restart during countdown: io (3) then dma (2)
        @(negedge clk);
        cyc_start = 1'b1; cyc_master = 2'd0; cyc_io = 1'b1; cyc_addr = 16'h0;
        @(negedge clk);
        check(ready, 1'b0, "R9 first cycle running");
        cyc_master = 2'd1; cyc_io = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        check(ready, 1'b0, "R9 reload wait 1");
        @(negedge clk);
        check(ready, 1'b0, "R9 reload wait 2");
        @(negedge clk);
        check(ready, 1'b1, "R9 reload done");

        // R10 write mid-countdown
        @(negedge clk);
        cyc_start = 1'b1; cyc_master = 2'd0; cyc_io = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        check(ready, 1'b0, "R10 wait 1");
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0000;
        @(negedge clk);
        cfg_we = 1'b0;
        check(ready, 1'b0, "R10 wait 2");
        @(negedge clk);
        check(ready, 1'b0, "R10 wait 3");
        @(negedge clk);
        check(ready, 1'b1, "R10 done");
        rd(2'd0, 16'h0000, "R8 zero written");
        run_cycle(2'd0, 1'b1, 16'h0, 0, "R3 io count zero");
        run_cycle(2'd1, 1'b0, 16'h0, 0, "R3 dma count zero");

        // R7 reordered boundaries: lo=8 hi=4
        wr(2'd0, 16'h06C9);
        wr(2'd1, 16'h0008);
        wr(2'd2, 16'h0004);
        rd(2'd1, 16'h0008, "R8 low boundary write");
        run_cycle(2'd0, 1'b0, 16'h5000, 1, "R7 below low boundary");
        run_cycle(2'd0, 1'b0, 16'h9000, 0, "R7 above both boundaries");
        // R7 empty middle: lo=hi=2
        wr(2'd1, 16'h0002);
        wr(2'd2, 16'h0002);
        run_cycle(2'd0, 1'b0, 16'h1FFF, 1, "R7 empty middle low");
        run_cycle(2'd0, 1'b0, 16'h2000, 0, "R7 empty middle high");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule